// File: doc/BRIEF.md
# Triggered Pixel Hit Buffer Readout

A small matrix of pixel cells, each with its own storage, sits in front of a shared readout port. When a pixel's discriminator pulse is seen on a clock edge, that pixel's cell records the free-running timestamp present on the same edge and marks itself occupied. The cell then holds the hit until the readout takes it. While a cell is occupied, further pulses on that pixel are dropped.

In free-running mode every occupied cell can be read at once. In triggered mode a cell must first be confirmed. The age of the hit is the current timestamp minus the stored one, taken modulo 2^TS_W. If the trigger strobe is high on the edge where that age equals the programmed latency, the cell is confirmed. If the strobe is low on that edge, the cell is emptied. A fixed-priority picker then drains the readable cells, one word per clock while readout is enabled. Each word carries the row, the column and the stored timestamp.

Top module: `pix_trig_readout`

## Requirements
- R1: While reset is asserted, and after it is released, rd_valid_o is low and every cell is empty, so no word appears until a new hit is captured.
- R2: A hit pulse on an empty cell, seen on a clock edge, stores the ts_i value present on that edge. The cell becomes occupied from the next cycle.
- R3: A hit pulse on an occupied cell is ignored. The timestamp reported later is the one from the first hit.
- R4: With trig_mode_i = 0 (free-running), every occupied cell can be read, and the trigger strobe has no effect.
- R5: With trig_mode_i = 1, an occupied cell is confirmed when trig_i is high on the edge where (ts_i - stored timestamp) mod 2^TS_W equals lat_i. Only confirmed cells can be read.
- R6: With trig_mode_i = 1, a cell whose age equals lat_i on an edge where trig_i is low is emptied and never read. A trigger on any other edge has no effect on that cell.
- R7: The age comparison is modular, so hits stored just before the timestamp wraps are confirmed or expired exactly as hits stored elsewhere.
- R8: Among readable cells, the one with the lowest index row*COLS+col is read first. This means lowest row first, then lowest column.
- R9: On each edge with rd_en_i high and at least one readable cell, one word is registered: rd_valid_o goes high on the next cycle and the read cell is emptied on that same edge. With no readable cell, rd_valid_o is low.
- R10: With rd_en_i low, rd_valid_o is low and the cells keep their contents.
- R11: A word holds rd_row_o = index / COLS, rd_col_o = index mod COLS, and rd_ts_o = the stored timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | ROWS*COLS | Per-pixel hit pulse; bit index = row*COLS+col |
| ts_i | input | TS_W | Free-running timestamp |
| trig_i | input | 1 | Trigger strobe |
| lat_i | input | TS_W | Trigger latency in timestamp counts |
| trig_mode_i | input | 1 | 0 = free-running, 1 = triggered |
| rd_en_i | input | 1 | Readout enable |
| rd_valid_o | output | 1 | Word valid |
| rd_row_o | output | ROW_W | Row of the word |
| rd_col_o | output | COL_W | Column of the word |
| rd_ts_o | output | TS_W | Stored timestamp of the word |

## Verification
A hit sampled on edge N makes its cell occupied after N. In free-running mode, the earliest that cell's word can appear is at the outputs after edge N+1. In triggered mode, confirmation happens on the edge where the age equals the latency, and the word can appear one edge later at the earliest. Lower-index cells that are waiting delay it further. The bench drives all inputs on falling edges and advances the timestamp there. It keeps a per-pixel reference of occupancy, confirmation and stored time, which it updates on each rising edge. It compares the registered outputs at the next falling edge, so every result is checked in the cycle it is due. The sweeps run every latency from 1 to 31, with the trigger one early, on time and one late. The timestamp wraps many times during the run.

// File: rtl/pix_readout_pkg.sv
package pix_readout_pkg;
  typedef enum logic {
    MODE_FREE = 1'b0,
    MODE_TRIG = 1'b1
  } acq_mode_e;

  localparam int DEF_ROWS = 4;
  localparam int DEF_COLS = 4;
  localparam int DEF_TS_W = 5;
endpackage

// File: rtl/pix_hit_cell.sv
module pix_hit_cell
  import pix_readout_pkg::*;
#(
  parameter int TS_W = DEF_TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic [TS_W-1:0] lat_i,
  input  logic            trig_i,
  input  logic            trig_mode_i,
  input  logic            clr_i,
  output logic            occ_o,
  output logic            ready_o,
  output logic [TS_W-1:0] ts_o
);
  logic            occ_q, occ_d;
  logic            cnf_q, cnf_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic [TS_W-1:0] age;
  logic            at_window;
  logic            trig_mode;

  assign trig_mode = (trig_mode_i == MODE_TRIG);
  assign age       = ts_i - ts_q;
  assign at_window = occ_q && !cnf_q && (age == lat_i);

  always_comb begin
    occ_d = occ_q;
    cnf_d = cnf_q;
    ts_d  = ts_q;
    if (clr_i) begin
      occ_d = 1'b0;
      cnf_d = 1'b0;
    end else if (occ_q) begin
      if (trig_mode && at_window) begin
        if (trig_i) cnf_d = 1'b1;
        else        occ_d = 1'b0;
      end
    end else if (hit_i) begin
      occ_d = 1'b1;
      ts_d  = ts_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
      cnf_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      occ_q <= occ_d;
      cnf_q <= cnf_d;
      if (!occ_q) ts_q <= ts_d;
    end
  end

  assign occ_o   = occ_q;
  assign ready_o = trig_mode ? cnf_q : occ_q;
  assign ts_o    = ts_q;

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q |=> (!occ_q || $stable(ts_q)));
  assert_cnf_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnf_q |-> occ_q);
  assert_cnf_after_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnf_q) |-> $past(trig_i));
  assert_free_no_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnf_q) |-> $past(trig_mode_i == MODE_TRIG));
endmodule

// File: rtl/pix_prio_pick.sv
module pix_prio_pick #(
  parameter int N   = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
    grant_o = '0;
    if (any_o) grant_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/pix_trig_readout.sv
module pix_trig_readout
  import pix_readout_pkg::*;
#(
  parameter int ROWS  = DEF_ROWS,
  parameter int COLS  = DEF_COLS,
  parameter int TS_W  = DEF_TS_W,
  localparam int NPIX  = ROWS * COLS,
  localparam int IW    = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIX-1:0]  hit_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             trig_i,
  input  logic [TS_W-1:0]  lat_i,
  input  logic             trig_mode_i,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic [TS_W-1:0]  rd_ts_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPIX-1:0] cell_occ, cell_ready, pick_grant, cell_clr;
  logic [TS_W-1:0] cell_ts [NPIX];
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar p = 0; p < NPIX; p++) begin : g_cell
    pix_hit_cell #(.TS_W(TS_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .hit_i      (hit_i[p]),
      .ts_i       (ts_i),
      .lat_i      (lat_i),
      .trig_i     (trig_i),
      .trig_mode_i(trig_mode_i),
      .clr_i      (cell_clr[p]),
      .occ_o      (cell_occ[p]),
      .ready_o    (cell_ready[p]),
      .ts_o       (cell_ts[p])
    );
  end

  pix_prio_pick #(.N(NPIX)) u_pick (
    .req_i  (cell_ready),
    .grant_o(pick_grant),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign take     = rd_en_i && pick_any;
  assign cell_clr = take ? pick_grant : '0;

  logic             valid_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic [TS_W-1:0]  tsw_d;

  always_comb begin
    valid_d = take;
    row_d   = ROW_W'(32'(pick_idx) / COLS);
    col_d   = COL_W'(32'(pick_idx) % COLS);
    tsw_d   = cell_ts[pick_idx];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_o <= 1'b0;
      rd_row_o   <= '0;
      rd_col_o   <= '0;
      rd_ts_o    <= '0;
    end else begin
      rd_valid_o <= valid_d;
      if (take) begin
        rd_row_o <= row_d;
        rd_col_o <= col_d;
        rd_ts_o  <= tsw_d;
      end
    end
  end

  logic [IW-1:0] last_idx;
  assign last_idx = IW'(32'(rd_row_o) * COLS + 32'(rd_col_o));

  assert_valid_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid_o |-> $past(rd_en_i));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid_o |-> !cell_occ[last_idx]);
endmodule

// File: tb/tb_pix_trig_readout.sv
module tb_pix_trig_readout;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int TS_W = 5;
  localparam int NPIX = ROWS * COLS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [NPIX-1:0] hit_i;
  logic [TS_W-1:0] ts_i = '0;
  logic            trig_i;
  logic [TS_W-1:0] lat_i;
  logic            trig_mode_i;
  logic            rd_en_i;
  logic            rd_valid_o;
  logic [1:0]      rd_row_o;
  logic [1:0]      rd_col_o;
  logic [TS_W-1:0] rd_ts_o;

  pix_trig_readout #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_i(ts_i), .trig_i(trig_i),
    .lat_i(lat_i), .trig_mode_i(trig_mode_i), .rd_en_i(rd_en_i),
    .rd_valid_o(rd_valid_o), .rd_row_o(rd_row_o), .rd_col_o(rd_col_o),
    .rd_ts_o(rd_ts_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";
  bit    done     = 1'b0;

  always @(negedge clk) ts_i <= ts_i + 1'b1;

  // Reference state, built from R2..R11
  logic            m_occ [NPIX];
  logic            m_cnf [NPIX];
  logic [TS_W-1:0] m_ts  [NPIX];
  logic            m_valid;
  int              m_row, m_col;
  logic [TS_W-1:0] m_tsw;
  int              m_sel;
  logic [TS_W-1:0] m_age;
  logic            m_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++) begin
        m_occ[p] = 1'b0; m_cnf[p] = 1'b0; m_ts[p] = '0;
      end
      m_valid = 1'b0;
    end else begin
      m_sel = -1;
      for (int p = NPIX - 1; p >= 0; p--) begin
        m_rdy = trig_mode_i ? m_cnf[p] : m_occ[p];
        if (m_rdy) m_sel = p;
      end
      m_valid = rd_en_i && (m_sel >= 0);
      if (m_valid) begin
        m_row = m_sel / COLS; m_col = m_sel % COLS; m_tsw = m_ts[m_sel];
      end
      for (int p = 0; p < NPIX; p++) begin
        m_age = ts_i - m_ts[p];
        if (m_valid && p == m_sel) begin
          m_occ[p] = 1'b0; m_cnf[p] = 1'b0;
        end else if (m_occ[p]) begin
          if (trig_mode_i && !m_cnf[p] && m_age == lat_i) begin
            if (trig_i) m_cnf[p] = 1'b1;
            else        m_occ[p] = 1'b0;
          end
        end else if (hit_i[p]) begin
          m_occ[p] = 1'b1; m_ts[p] = ts_i;
        end
      end
    end
  end

  // Output comparison away from the active edge (R9, R11 plus current phase)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (rd_valid_o !== m_valid) begin
        n_fail++;
        $display("FAIL %s R9 valid: actual %0b expected %0b", phase, rd_valid_o, m_valid);
      end else if (m_valid) begin
        n_checks++;
        if (rd_row_o !== 2'(m_row) || rd_col_o !== 2'(m_col) || rd_ts_o !== m_tsw) begin
          n_fail++;
          $display("FAIL %s R11 word: actual r%0d c%0d t%0d expected r%0d c%0d t%0d",
                   phase, rd_row_o, rd_col_o, rd_ts_o, m_row, m_col, m_tsw);
        end
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_hit(logic [NPIX-1:0] pat);
    hit_i = pat; tick(1); hit_i = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hit_i = '0; trig_i = 1'b0; lat_i = 5'd4;
    trig_mode_i = 1'b0; rd_en_i = 1'b0;
    tick(3);
    // R1: outputs idle during reset
    n_checks++;
    if (rd_valid_o !== 1'b0) begin
      n_fail++; $display("FAIL R1 reset valid: actual %0b expected 0", rd_valid_o);
    end
    rst_n = 1'b1;
    tick(4);
    // R1: nothing to read after release
    phase = "R1"; rd_en_i = 1'b1; tick(4); rd_en_i = 1'b0;

    // R2 R8 R10: capture with readout held off, then drain in priority order
    phase = "R2 R8 R10";
    pulse_hit(16'hA5C3);
    tick(5);
    pulse_hit(16'h5A3C);
    tick(3);
    rd_en_i = 1'b1; tick(20);

    // R3: repeated hits on a busy pixel keep the first timestamp
    phase = "R3";
    rd_en_i = 1'b0;
    pulse_hit(16'h0020); tick(2);
    pulse_hit(16'h0020); pulse_hit(16'h0021); tick(3);
    pulse_hit(16'h0020);
    rd_en_i = 1'b1; tick(6);

    // R4 R8 R9: free-running sweep with trigger noise, readout always on
    phase = "R4 R8 R9";
    for (int k = 0; k < 60; k++) begin
      trig_i = k[0];
      pulse_hit(16'((k * 40503 + 7) & 16'hFFFF));
      if (k % 3 == 0) tick(NPIX + 1);
    end
    trig_i = 1'b0; tick(NPIX + 2);

    // R5 R6 R7: triggered mode, every latency, trigger early / on time / late
    phase = "R5 R6 R7";
    trig_mode_i = 1'b1;
    tick(2);
    for (int lat = 1; lat < 32; lat++) begin
      for (int off = -1; off <= 1; off++) begin
        lat_i = 5'(lat);
        pulse_hit(16'(1 << (lat % NPIX)) | 16'(1 << ((lat + 5) % NPIX)));
        if (lat + off - 1 > 0) tick(lat + off - 1);
        trig_i = 1'b1; tick(1); trig_i = 1'b0;
        tick(4);
      end
    end

    // R5 R8 R10: confirmed hits wait while readout is off, then drain
    phase = "R5 R8 R10";
    rd_en_i = 1'b0; lat_i = 5'd3;
    pulse_hit(16'hF00F); tick(2);
    trig_i = 1'b1; tick(1); trig_i = 1'b0;
    tick(10);
    rd_en_i = 1'b1; tick(12);

    // R4: leaving triggered mode makes pending hits readable
    phase = "R4";
    rd_en_i = 1'b0; lat_i = 5'd20;
    pulse_hit(16'h0180); tick(3);
    trig_mode_i = 1'b0; rd_en_i = 1'b1; tick(6);

    finish_run();
  end
endmodule